// File: doc/BRIEF.md
# Power Switch Fault Supervisor

This block is the digital fault manager of a hot-swap power switch controller. It receives already-synchronized comparator flags (undervoltage and overvoltage on several rails, overtemperature, overcurrent, short-circuit, a current-monitor pin short, start-up timeout and two FET health checks). It also receives an external pulldown on the switch-enable line and a flag that marks the inrush phase. From these it decides whether the pass FET gate may be driven and whether the open-drain fault line must be pulled low.

Each fault class has its own response and its own qualification delay in clock cycles. Some faults only hold the switch off while they last and raise no flag. Some raise the flag while they last, either with or without turning the switch off. The rest set a sticky latch that holds the switch off and the flag low. Only a power-on reset or a deep-shutdown level on the enable input clears that latch. A parameter selects latch-off or auto-retry. In auto-retry mode the latch releases itself after a fixed number of cycles.

Top module: `pwr_fault_sup`

## Requirements
- R1: After reset with every input low, `gate_on` is 1 and `flt_pull` is 0.
- R2: Any of `en_uv`, `bias_uv`, `vin_uv` or `vin_ov` high at a rising edge makes `gate_on` 0 after that edge without raising `flt_pull`. The gate returns after the first edge at which all four are low. Nothing is latched.
- R3: `ot` high at one rising edge latches a fault after that edge: `gate_on` 0 and `flt_pull` 1, and both stay after `ot` falls.
- R4: Outside inrush (`inrush` 0), `oc` high at CB_DLY+1 consecutive edges latches a fault after the last of them. High at CB_DLY edges or fewer has no effect, and any low edge restarts the count.
- R5: During inrush, `oc` qualified as in R4 raises `flt_pull` but keeps `gate_on` 1 and latches nothing. `flt_pull` falls after the first edge with `oc` low.
- R6: `sc` high at FT_DLY+1 consecutive edges latches a fault.
- R7: `imon_bkp` high at SPF_DLY+1 consecutive edges latches a fault.
- R8: `su_tmo` high at SU_DLY+1 consecutive edges latches a fault. `fet_gs` high at GS_DLY+1 consecutive edges latches a fault.
- R9: `fet_ds` high at SU_DLY+1 consecutive edges makes `gate_on` 0 and `flt_pull` 1 without latching. Both recover after the first edge with `fet_ds` low.
- R10: `swen_low` latches a fault at the first edge at which it is high while all four inputs of R2 are low. While any of them is high, `swen_low` has no effect.
- R11: `en_deep` high clears a latched fault after that edge and holds `gate_on` 0 while it stays high. A pulse on `en_uv` does not clear a latched fault.
- R12: With AUTO_RETRY 0 a latched fault persists without limit. With AUTO_RETRY 1 it releases after RETRY_CYC edges unless a latching condition is present again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, clears all state |
| en_uv | input | 1 | Enable input below its undervoltage-lockout level |
| en_deep | input | 1 | Enable input below the deep-shutdown level |
| bias_uv | input | 1 | Internal bias supply undervoltage |
| vin_uv | input | 1 | Input rail undervoltage |
| vin_ov | input | 1 | Input rail overvoltage |
| ot | input | 1 | Overtemperature |
| oc | input | 1 | Load current above the breaker threshold |
| sc | input | 1 | Short-circuit comparator |
| imon_bkp | input | 1 | Monitor pin shorted and current above backup threshold |
| su_tmo | input | 1 | Start-up timer expired condition |
| fet_gs | input | 1 | FET gate-to-source health fault |
| fet_ds | input | 1 | FET drain-to-source health fault |
| swen_low | input | 1 | Switch-enable line pulled low externally |
| inrush | input | 1 | 1 during start-up, 0 in steady state |
| gate_on | output | 1 | Permission to drive the pass FET gate |
| flt_pull | output | 1 | 1 pulls the open-drain fault line low |

## Verification
The assertions assume every input is already synchronous to `clk` and free of glitches. They also assume `en_deep` is held for at least one full edge, because the latch and its retry count are both sampled from it. The bench keeps to this by changing inputs only on falling edges and by raising one fault source at a time. An exception is the deliberate overlap of `swen_low` with an overvoltage, which R10 requires. A deep-shutdown pulse between scenarios makes each one start from a cleared latch.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    // Indices of the delay-qualified fault sources
    localparam int QI_OC   = 0;
    localparam int QI_SC   = 1;
    localparam int QI_IMON = 2;
    localparam int QI_SU   = 3;
    localparam int QI_GS   = 4;
    localparam int QI_DS   = 5;
    localparam int NQ      = 6;

    typedef struct packed {
        logic stop;   // non-latched gate removal
        logic ind;    // non-latched fault indication
    } live_t;
endpackage

// File: rtl/pfs_qual.sv
module pfs_qual #(
    parameter int DLY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_in,
    output logic qual
);
    localparam int W = $clog2(DLY + 1);
    localparam logic [W-1:0] LIMIT = W'(DLY);

    typedef struct packed {
        logic [W-1:0] cnt;
    } qst_t;

    qst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!fault_in)
            st_d.cnt = '0;
        else if (st_q.cnt != LIMIT)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign qual = fault_in && (st_q.cnt == LIMIT);

    // R4: the counter never passes its limit
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIMIT);
    // R4: a low input restarts the qualification
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_in |=> (st_q.cnt == '0));
endmodule

// File: rtl/pfs_latch.sv
module pfs_latch #(
    parameter bit AUTO_RETRY = 1'b0,
    parameter int RETRY_CYC  = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic latched
);
    localparam int RW = $clog2(RETRY_CYC);
    localparam logic [RW-1:0] LAST = RW'(RETRY_CYC - 1);

    typedef struct packed {
        logic          hold;
        logic [RW-1:0] retry;
    } lst_t;

    lst_t st_d, st_q;
    logic expire;

    always_comb begin
        st_d   = st_q;
        expire = AUTO_RETRY && st_q.hold && (st_q.retry == LAST);
        if (clr) begin
            st_d.hold  = 1'b0;
            st_d.retry = '0;
        end else if (set) begin
            st_d.hold  = 1'b1;
            st_d.retry = (AUTO_RETRY && st_q.hold && !expire) ? st_q.retry + 1'b1 : '0;
        end else if (expire) begin
            st_d.hold  = 1'b0;
            st_d.retry = '0;
        end else if (AUTO_RETRY && st_q.hold) begin
            st_d.retry = st_q.retry + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latched = st_q.hold;

    // R11: deep shutdown always empties the latch
    a_r11_deep_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !latched);
    // R12: the retry count stays inside its period
    a_r12_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.retry <= LAST);

    generate
        if (!AUTO_RETRY) begin : g_latch_off
            // R12: in latch-off mode only deep shutdown releases the latch
            a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (latched && !clr) |=> latched);
        end
    endgenerate
endmodule

// File: rtl/pwr_fault_sup.sv
module pwr_fault_sup
    import pfs_pkg::*;
#(
    parameter int CB_DLY     = 1000,
    parameter int FT_DLY     = 8,
    parameter int SPF_DLY    = 2500,
    parameter int SU_DLY     = 5000,
    parameter int GS_DLY     = 500,
    parameter bit AUTO_RETRY = 1'b0,
    parameter int RETRY_CYC  = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_uv,
    input  logic en_deep,
    input  logic bias_uv,
    input  logic vin_uv,
    input  logic vin_ov,
    input  logic ot,
    input  logic oc,
    input  logic sc,
    input  logic imon_bkp,
    input  logic su_tmo,
    input  logic fet_gs,
    input  logic fet_ds,
    input  logic swen_low,
    input  logic inrush,
    output logic gate_on,
    output logic flt_pull
);
    localparam int DLY_TAB [NQ] = '{CB_DLY, FT_DLY, SPF_DLY, SU_DLY, GS_DLY, SU_DLY};

    logic [NQ-1:0] raw, qual;
    logic          rail_bad, latch_set, latched;
    live_t         live_d, live_q;

    assign raw = {fet_ds, fet_gs, su_tmo, imon_bkp, sc, oc};

    generate
        for (genvar i = 0; i < NQ; i++) begin : g_qual
            pfs_qual #(.DLY(DLY_TAB[i])) u_qual (
                .clk      (clk),
                .rst_n    (rst_n),
                .fault_in (raw[i]),
                .qual     (qual[i])
            );
        end
    endgenerate

    always_comb begin
        rail_bad  = en_uv || bias_uv || vin_uv || vin_ov;
        latch_set = ot
                 || (qual[QI_OC] && !inrush)
                 || qual[QI_SC]
                 || qual[QI_IMON]
                 || qual[QI_SU]
                 || qual[QI_GS]
                 || (swen_low && !rail_bad);
        live_d.stop = rail_bad || en_deep || qual[QI_DS];
        live_d.ind  = qual[QI_DS] || (qual[QI_OC] && inrush);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end

    pfs_latch #(.AUTO_RETRY(AUTO_RETRY), .RETRY_CYC(RETRY_CYC)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (latch_set),
        .clr     (en_deep),
        .latched (latched)
    );

    assign gate_on  = !latched && !live_q.stop;
    assign flt_pull = latched || live_q.ind;

    // R2: any rail problem removes the gate on the next cycle
    a_r2_rail_off: assert property (@(posedge clk) disable iff (!rst_n)
        rail_bad |=> !gate_on);
    // R3: overtemperature trips and flags at once
    a_r3_ot_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (ot && !en_deep) |=> (!gate_on && flt_pull));
    // R11: deep shutdown keeps the gate off
    a_r11_deep_off: assert property (@(posedge clk) disable iff (!rst_n)
        en_deep |=> !gate_on);
endmodule

// File: tb/tb_pwr_fault_sup.sv
module tb_pwr_fault_sup;
    localparam int CB = 6, FT = 2, SPF = 5, SU = 7, GS = 3, RTY = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en_uv, en_deep, bias_uv, vin_uv, vin_ov, ot, oc, sc;
    logic imon_bkp, su_tmo, fet_gs, fet_ds, swen_low, inrush;
    logic gate_on, flt_pull, gate_rt, flt_rt;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwr_fault_sup #(.CB_DLY(CB), .FT_DLY(FT), .SPF_DLY(SPF), .SU_DLY(SU),
                    .GS_DLY(GS), .AUTO_RETRY(1'b0), .RETRY_CYC(RTY)) dut (
        .clk(clk), .rst_n(rst_n), .en_uv(en_uv), .en_deep(en_deep), .bias_uv(bias_uv),
        .vin_uv(vin_uv), .vin_ov(vin_ov), .ot(ot), .oc(oc), .sc(sc), .imon_bkp(imon_bkp),
        .su_tmo(su_tmo), .fet_gs(fet_gs), .fet_ds(fet_ds), .swen_low(swen_low),
        .inrush(inrush), .gate_on(gate_on), .flt_pull(flt_pull));

    pwr_fault_sup #(.CB_DLY(CB), .FT_DLY(FT), .SPF_DLY(SPF), .SU_DLY(SU),
                    .GS_DLY(GS), .AUTO_RETRY(1'b1), .RETRY_CYC(RTY)) dut_rt (
        .clk(clk), .rst_n(rst_n), .en_uv(en_uv), .en_deep(en_deep), .bias_uv(bias_uv),
        .vin_uv(vin_uv), .vin_ov(vin_ov), .ot(ot), .oc(oc), .sc(sc), .imon_bkp(imon_bkp),
        .su_tmo(su_tmo), .fet_gs(fet_gs), .fet_ds(fet_ds), .swen_low(swen_low),
        .inrush(inrush), .gate_on(gate_rt), .flt_pull(flt_rt));

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic g, input logic f,
                         input logic eg, input logic ef);
        checks++;
        if (g !== eg || f !== ef) begin
            fails++;
            $display("FAIL %s gate_on=%b flt_pull=%b expected gate_on=%b flt_pull=%b",
                     req, g, f, eg, ef);
        end
    endtask

    task automatic set_q(input int idx, input logic v);
        case (idx)
            0: oc = v;
            1: sc = v;
            2: imon_bkp = v;
            3: su_tmo = v;
            4: fet_gs = v;
            default: fet_ds = v;
        endcase
    endtask

    task automatic deep_clear();
        en_deep = 1'b1; step(1);
        en_deep = 1'b0; step(1);
    endtask

    task automatic t_reset();
        check("R1", gate_on, flt_pull, 1'b1, 1'b0);
    endtask

    task automatic t_rails();
        en_uv = 1'b1; step(1);
        check("R2 en_uv", gate_on, flt_pull, 1'b0, 1'b0);
        en_uv = 1'b0; bias_uv = 1'b1; step(1);
        check("R2 bias_uv", gate_on, flt_pull, 1'b0, 1'b0);
        bias_uv = 1'b0; vin_uv = 1'b1; step(1);
        check("R2 vin_uv", gate_on, flt_pull, 1'b0, 1'b0);
        vin_uv = 1'b0; vin_ov = 1'b1; step(3);
        check("R2 vin_ov", gate_on, flt_pull, 1'b0, 1'b0);
        vin_ov = 1'b0; step(1);
        check("R2 release", gate_on, flt_pull, 1'b1, 1'b0);
    endtask

    task automatic t_ot();
        ot = 1'b1; step(1); ot = 1'b0; step(3);
        check("R3 latched", gate_on, flt_pull, 1'b0, 1'b1);
        deep_clear();
        check("R11 cleared", gate_on, flt_pull, 1'b1, 1'b0);
    endtask

    task automatic t_latch_q(input int idx, input int dly, input string req);
        set_q(idx, 1'b1); step(dly);
        check({req, " before"}, gate_on, flt_pull, 1'b1, 1'b0);
        step(1);
        check({req, " trip"}, gate_on, flt_pull, 1'b0, 1'b1);
        set_q(idx, 1'b0); step(3);
        check({req, " held"}, gate_on, flt_pull, 1'b0, 1'b1);
        deep_clear();
    endtask

    task automatic t_oc_transient();
        oc = 1'b1; step(CB); oc = 1'b0; step(1);
        oc = 1'b1; step(CB); oc = 1'b0; step(2);
        check("R4 transient", gate_on, flt_pull, 1'b1, 1'b0);
    endtask

    task automatic t_inrush();
        inrush = 1'b1; oc = 1'b1; step(CB);
        check("R5 before", gate_on, flt_pull, 1'b1, 1'b0);
        step(1);
        check("R5 limit", gate_on, flt_pull, 1'b1, 1'b1);
        step(4);
        check("R5 persist", gate_on, flt_pull, 1'b1, 1'b1);
        oc = 1'b0; step(1);
        check("R5 release", gate_on, flt_pull, 1'b1, 1'b0);
        inrush = 1'b0; step(1);
    endtask

    task automatic t_ds();
        fet_ds = 1'b1; step(SU);
        check("R9 before", gate_on, flt_pull, 1'b1, 1'b0);
        step(1);
        check("R9 trip", gate_on, flt_pull, 1'b0, 1'b1);
        fet_ds = 1'b0; step(1);
        check("R9 release", gate_on, flt_pull, 1'b1, 1'b0);
    endtask

    task automatic t_swen();
        vin_ov = 1'b1; swen_low = 1'b1; step(2);
        check("R10 masked", gate_on, flt_pull, 1'b0, 1'b0);
        vin_ov = 1'b0; swen_low = 1'b0; step(1);
        check("R10 ignored", gate_on, flt_pull, 1'b1, 1'b0);
        swen_low = 1'b1; step(1); swen_low = 1'b0; step(2);
        check("R10 latched", gate_on, flt_pull, 1'b0, 1'b1);
        deep_clear();
    endtask

    task automatic t_uv_no_clear();
        ot = 1'b1; step(1); ot = 1'b0;
        en_uv = 1'b1; step(2); en_uv = 1'b0; step(2);
        check("R11 uv keeps latch", gate_on, flt_pull, 1'b0, 1'b1);
        en_deep = 1'b1; step(1);
        check("R11 deep off", gate_on, flt_pull, 1'b0, 1'b0);
        en_deep = 1'b0; step(1);
        check("R11 deep release", gate_on, flt_pull, 1'b1, 1'b0);
    endtask

    task automatic t_retry();
        deep_clear();
        sc = 1'b1; step(FT + 1); sc = 1'b0;
        check("R12 rt trip", gate_rt, flt_rt, 1'b0, 1'b1);
        step(RTY - 1);
        check("R12 rt still", gate_rt, flt_rt, 1'b0, 1'b1);
        step(1);
        check("R12 rt release", gate_rt, flt_rt, 1'b1, 1'b0);
        step(RTY);
        check("R12 latch-off holds", gate_on, flt_pull, 1'b0, 1'b1);
        ot = 1'b1; step(1); ot = 1'b0; step(RTY - 3);
        deep_clear();
        ot = 1'b1; step(1); ot = 1'b0; step(RTY - 1);
        check("R12 rt timer restarted", gate_rt, flt_rt, 1'b0, 1'b1);
        step(1);
        check("R12 rt full period", gate_rt, flt_rt, 1'b1, 1'b0);
        deep_clear();
    endtask

    initial begin
        en_uv = 0; en_deep = 0; bias_uv = 0; vin_uv = 0; vin_ov = 0; ot = 0;
        oc = 0; sc = 0; imon_bkp = 0; su_tmo = 0; fet_gs = 0; fet_ds = 0;
        swen_low = 0; inrush = 0;
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_rails();
        t_ot();
        t_oc_transient();
        t_latch_q(0, CB, "R4");
        t_inrush();
        t_latch_q(1, FT, "R6");
        t_latch_q(2, SPF, "R7");
        t_latch_q(3, SU, "R8 su_tmo");
        t_latch_q(4, GS, "R8 fet_gs");
        t_ds();
        t_swen();
        t_uv_no_clear();
        t_retry();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule